// File: doc/BRIEF.md
# Soft-Reset Attention Pin Controller

This block watches the stream of host writes into the ATA command register and reacts when the ATAPI soft reset opcode appears. One shared pad can take one of four roles, chosen by a 2-bit role select. It can be an open-drain general-purpose line, a plain push-pull output bit, a self-timed active-low reset pulse, or an active-low level that holds until firmware acknowledges it. A second, separate active-low interrupt line can also be raised on the same opcode, so that the local microcontroller learns of the soft reset.

The pad is modelled as an output-enable plus a data bit. In the open-drain roles the block drives the pad low only by raising the output-enable, with the data bit held at 0. A released pad means the output-enable is low. Firmware clears the latched indication and the interrupt by writing to an acknowledge register. The value written does not matter, so only the write strobe enters the block.

Top module: `srst_pin_ctrl`

## Requirements
- R1: After reset the indication and the interrupt are both inactive (`irq_n` = 1, and in role 00 with `gpio_val` = 1, `pin_oe` = 0).
- R2: In role 00 (general-purpose), `pin_oe` = NOT `gpio_val` and `pin_dout` = 0. A soft reset opcode leaves the pad untouched in this role.
- R3: In role 01 (plain output), `pin_oe` = 1 and `pin_dout` follows `out_val`.
- R4: The indication starts only on a clock where `host_cmd_wr` = 1, `host_cmd_data` = 8'h08 and `pin_sel[1]` = 1. Other opcodes, and data 8'h08 without the strobe, have no effect.
- R5: In role 10 (auto-timed pulse), the pad is driven low (`pin_oe` = 1, `pin_dout` = 0) for exactly 256 clocks, counted from the first clock after the opcode write, and is then released.
- R6: In role 10, a new opcode write while a pulse is active restarts the full 256-clock count.
- R7: In role 11 (latched), the pad stays driven low until a clock with `fw_ack_wr` = 1, after which it is released. It does not time out.
- R8: When `irq_en` = 1, an opcode write drives `irq_n` low from the next clock, and it stays low until `fw_ack_wr`. When `irq_en` = 0, an opcode write leaves `irq_n` unchanged.
- R9: A clock with `pin_sel[1]` = 0 cancels any active indication. When an opcode write and an acknowledge arrive on the same clock, the opcode wins for both the indication and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cmd_wr | input | 1 | Host write strobe to the command register |
| host_cmd_data | input | 8 | Byte written by the host |
| fw_ack_wr | input | 1 | Firmware write strobe to the acknowledge register |
| pin_sel | input | 2 | Pad role: 00 open-drain I/O, 01 output bit, 10 timed pulse, 11 latched level |
| irq_en | input | 1 | Enables the interrupt on the soft reset opcode |
| gpio_val | input | 1 | Open-drain data in role 00 (0 pulls low) |
| out_val | input | 1 | Data bit in role 01 |
| pin_oe | output | 1 | Pad output-enable |
| pin_dout | output | 1 | Pad output data |
| irq_n | output | 1 | Active-low interrupt to the microcontroller |

## Verification
The assertions assume that every input is synchronous to `clk` and is stable at the rising edge. They also assume that an acknowledge is a one-clock strobe, and that the role select may change on any clock. The bench changes every input only at the falling edge and holds it across the next rising edge. It switches the role select, including in the middle of an active pulse or latch. This covers the cancellation path and the same-clock collision of an opcode write and an acknowledge. No input ever changes near the sampling edge.

// File: rtl/srst_pkg.sv
package srst_pkg;

  typedef enum logic [1:0] {
    ROLE_GPIO   = 2'b00,
    ROLE_DOUT   = 2'b01,
    ROLE_PULSE  = 2'b10,
    ROLE_LATCH  = 2'b11
  } pin_role_e;

  localparam logic [7:0] SOFT_RESET_OP = 8'h08;

  // A command write counts as a soft reset only with the strobe and the opcode.
  function automatic logic is_soft_reset(input logic wr, input logic [7:0] data);
    return wr && (data == SOFT_RESET_OP);
  endfunction

  // Reload value of the down-counter for a pulse of len clocks.
  function automatic int unsigned pulse_reload(input int unsigned len);
    return len - 1;
  endfunction

  // True for the roles in which the pad carries the soft-reset indication.
  function automatic logic role_is_indication(input pin_role_e role);
    return role[1];
  endfunction

endpackage

// File: rtl/srst_opcode_detect.sv
module srst_opcode_detect
  import srst_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [7:0] cmd_data,
  output logic       hit
);
  assign hit = is_soft_reset(cmd_wr, cmd_data);
endmodule

// File: rtl/srst_indicator.sv
module srst_indicator
  import srst_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 256
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  logic      ack,
  input  pin_role_e role,
  output logic      ind_act
);
  localparam int unsigned CW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(pulse_reload(PULSE_LEN));

  logic [CW-1:0] cnt;
  logic          armed_hit;
  logic          pulse_expire;
  logic          latch_clear;

  assign armed_hit    = hit && role_is_indication(role);
  assign pulse_expire = (role == ROLE_PULSE) && ind_act && (cnt == '0) && !hit;
  assign latch_clear  = (role == ROLE_LATCH) && ack && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ind_act <= 1'b0;
      cnt     <= '0;
    end else if (!role_is_indication(role)) begin
      ind_act <= 1'b0;
    end else if (armed_hit) begin
      ind_act <= 1'b1;
      cnt     <= RELOAD;
    end else if (latch_clear) begin
      ind_act <= 1'b0;
    end else if (role == ROLE_PULSE && ind_act) begin
      if (cnt == '0) ind_act <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  a_r4_rise_needs_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ind_act) |-> $past(armed_hit));

  a_r5_expire_releases: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_expire |=> !ind_act);

  a_r6_restart_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    armed_hit |=> (ind_act && cnt == RELOAD));

  a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_act && role == ROLE_LATCH && !ack) |=> ind_act);

  a_r9_low_select_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    !role_is_indication(role) |=> !ind_act);

endmodule

// File: rtl/srst_irq_latch.sv
module srst_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic irq_en,
  input  logic ack,
  output logic irq_pend
);
  logic irq_set;
  assign irq_set = hit && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_pend <= 1'b0;
    else if (irq_set) irq_pend <= 1'b1;
    else if (ack)     irq_pend <= 1'b0;
  end

  a_r8_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq_pend);

  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !ack) |=> irq_pend);

  a_r8_irq_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(irq_set));

endmodule

// File: rtl/srst_pin_mux.sv
module srst_pin_mux
  import srst_pkg::*;
(
  input  pin_role_e role,
  input  logic      gpio_val,
  input  logic      out_val,
  input  logic      ind_act,
  output logic      pin_oe,
  output logic      pin_dout
);
  always_comb begin
    unique case (role)
      ROLE_GPIO: begin pin_oe = !gpio_val; pin_dout = 1'b0;    end
      ROLE_DOUT: begin pin_oe = 1'b1;      pin_dout = out_val; end
      default:   begin pin_oe = ind_act;   pin_dout = 1'b0;    end
    endcase
  end

  // R2 / R5 / R7: in every open-drain role the pad is never driven high.
  always_comb begin
    if (role != ROLE_DOUT) a_r2_open_drain_low: assert (!pin_dout);
  end
endmodule

// File: rtl/srst_pin_ctrl.sv
module srst_pin_ctrl
  import srst_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_cmd_wr,
  input  logic [7:0] host_cmd_data,
  input  logic       fw_ack_wr,
  input  logic [1:0] pin_sel,
  input  logic       irq_en,
  input  logic       gpio_val,
  input  logic       out_val,
  output logic       pin_oe,
  output logic       pin_dout,
  output logic       irq_n
);
  pin_role_e role;
  logic      srst_hit;
  logic      ind_act;
  logic      irq_pend;

  assign role = pin_role_e'(pin_sel);

  srst_opcode_detect u_detect (
    .cmd_wr   (host_cmd_wr),
    .cmd_data (host_cmd_data),
    .hit      (srst_hit)
  );

  srst_indicator #(.PULSE_LEN(PULSE_LEN)) u_ind (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (srst_hit),
    .ack     (fw_ack_wr),
    .role    (role),
    .ind_act (ind_act)
  );

  srst_irq_latch u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (srst_hit),
    .irq_en   (irq_en),
    .ack      (fw_ack_wr),
    .irq_pend (irq_pend)
  );

  srst_pin_mux u_mux (
    .role     (role),
    .gpio_val (gpio_val),
    .out_val  (out_val),
    .ind_act  (ind_act),
    .pin_oe   (pin_oe),
    .pin_dout (pin_dout)
  );

  assign irq_n = !irq_pend;

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_n && !ind_act));

  a_r9_hit_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_hit && irq_en && fw_ack_wr) |=> !irq_n);

endmodule

// File: tb/test_srst_pin_ctrl.sv
`timescale 1ns/1ps
module test_srst_pin_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cmd_wr = 1'b0;
  logic [7:0] host_cmd_data = 8'h00;
  logic       fw_ack_wr = 1'b0;
  logic [1:0] pin_sel = 2'b00;
  logic       irq_en = 1'b0;
  logic       gpio_val = 1'b1;
  logic       out_val = 1'b0;
  logic       pin_oe, pin_dout, irq_n;

  int    tests = 0;
  int    fails = 0;
  string cur_req = "R1";

  // Behavioural reference state.
  bit m_act = 0;
  bit m_irq = 0;
  int m_left = 0;

  always #2.5 clk = ~clk;

  srst_pin_ctrl i_srst_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .host_cmd_wr(host_cmd_wr), .host_cmd_data(host_cmd_data),
    .fw_ack_wr(fw_ack_wr), .pin_sel(pin_sel), .irq_en(irq_en), .gpio_val(gpio_val),
    .out_val(out_val), .pin_oe(pin_oe), .pin_dout(pin_dout), .irq_n(irq_n)
  );

  task automatic check(string req, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit hit;
    hit = host_cmd_wr && (host_cmd_data == 8'h08);
    if (!rst_n) begin
      m_act = 0; m_irq = 0; m_left = 0;
      return;
    end
    if (!pin_sel[1]) m_act = 0;
    else if (hit) begin m_act = 1; m_left = 256; end
    else if (pin_sel == 2'b11 && fw_ack_wr) m_act = 0;
    else if (pin_sel == 2'b10 && m_act) begin
      m_left--;
      if (m_left == 0) m_act = 0;
    end
    if (hit && irq_en) m_irq = 1;
    else if (fw_ack_wr) m_irq = 0;
  endtask

  task automatic compare();
    logic e_oe, e_do;
    case (pin_sel)
      2'b00:   begin e_oe = !gpio_val; e_do = 1'b0;    end
      2'b01:   begin e_oe = 1'b1;      e_do = out_val; end
      default: begin e_oe = m_act;     e_do = 1'b0;    end
    endcase
    check(cur_req, "pin_oe", pin_oe, e_oe);
    check(cur_req, "pin_dout", pin_dout, e_do);
    check(cur_req, "irq_n", irq_n, !m_irq);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cmd(logic [7:0] d);
    host_cmd_wr = 1'b1; host_cmd_data = d;
    step();
    host_cmd_wr = 1'b0; host_cmd_data = 8'h00;
  endtask

  task automatic ack();
    fw_ack_wr = 1'b1;
    step();
    fw_ack_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int low;
    @(negedge clk);
    idle(3);
    rst_n = 1'b1;
    // R1: quiet after reset
    cur_req = "R1";
    idle(2);
    check("R1", "pin_oe after reset", pin_oe, 1'b0);
    check("R1", "irq_n after reset", irq_n, 1'b1);

    // R2: open-drain I/O follows gpio_val, opcode ignored on pad
    cur_req = "R2";
    gpio_val = 1'b0; idle(2);
    gpio_val = 1'b1; idle(2);
    cmd(8'h08); idle(3);
    check("R2", "pad released after opcode in GPIO role", pin_oe, 1'b0);

    // R3: plain output bit
    cur_req = "R3";
    pin_sel = 2'b01;
    out_val = 1'b1; idle(2);
    out_val = 1'b0; idle(2);
    out_val = 1'b1; idle(1);
    check("R3", "pin_dout follows out_val", pin_dout, 1'b1);

    // R4: only opcode 08h with strobe and indication role
    cur_req = "R4";
    pin_sel = 2'b10; idle(1);
    cmd(8'h90); cmd(8'h09); cmd(8'h88); cmd(8'h00);
    host_cmd_data = 8'h08; idle(3); host_cmd_data = 8'h00;
    check("R4", "no pulse from wrong opcode or missing strobe", pin_oe, 1'b0);

    // R5: exact 256-clock pulse
    cur_req = "R5";
    low = 0;
    host_cmd_wr = 1'b1; host_cmd_data = 8'h08;
    step();
    if (pin_oe) low++;
    host_cmd_wr = 1'b0; host_cmd_data = 8'h00;
    for (int i = 0; i < 300; i++) begin
      step();
      if (pin_oe) low++;
    end
    tests++;
    if (low != 256) begin
      fails++;
      $display("FAIL R5 pulse length: actual=%0d expected=256", low);
    end

    // R6: restart mid-pulse
    cur_req = "R6";
    cmd(8'h08); idle(100);
    cmd(8'h08); idle(200);
    check("R6", "pulse still active after restart", pin_oe, 1'b1);
    idle(100);
    check("R6", "pulse released after restarted count", pin_oe, 1'b0);

    // R7: latched level until acknowledge
    cur_req = "R7";
    pin_sel = 2'b11; idle(1);
    cmd(8'h08); idle(400);
    check("R7", "latched level holds", pin_oe, 1'b1);
    ack(); idle(2);
    check("R7", "latched level released by ack", pin_oe, 1'b0);

    // R8: interrupt output
    cur_req = "R8";
    irq_en = 1'b0;
    cmd(8'h08); idle(3);
    check("R8", "irq unchanged when disabled", irq_n, 1'b1);
    ack();
    irq_en = 1'b1;
    cmd(8'h08); idle(50);
    check("R8", "irq held low", irq_n, 1'b0);
    irq_en = 1'b0; idle(3);
    ack(); idle(2);
    check("R8", "irq released by ack", irq_n, 1'b1);

    // R9: role cancel and collision priority
    cur_req = "R9";
    irq_en = 1'b1;
    cmd(8'h08); idle(5);
    pin_sel = 2'b00; gpio_val = 1'b1; idle(1);
    pin_sel = 2'b11; idle(3);
    check("R9", "indication cancelled by low select", pin_oe, 1'b0);
    host_cmd_wr = 1'b1; host_cmd_data = 8'h08; fw_ack_wr = 1'b1;
    step();
    host_cmd_wr = 1'b0; host_cmd_data = 8'h00; fw_ack_wr = 1'b0;
    idle(3);
    check("R9", "opcode wins over ack (pad)", pin_oe, 1'b1);
    check("R9", "opcode wins over ack (irq)", irq_n, 1'b0);
    pin_sel = 2'b10; idle(300);
    ack(); idle(2);

    finish_run();
  end
endmodule